// File: doc/BRIEF.md
# Immediate-Extension Prefix Decoder

This decode-stage unit sits in front of the execute stage of a 16-bit load-store pipeline. It builds the immediate operand of each instruction. A special prefix word carries a 12-bit payload, and the unit holds that payload until the next real instruction arrives. The payload then combines with that instruction's own immediate field, which is either 4 bits wide or absent.

Combining the two lets short encodings reach full-width constants. A load-immediate gets its upper twelve bits from the prefix. A register-indirect load or store gains a signed byte offset in the range of about ±2 KiB. A plain register-register add becomes a three-operand add with a constant from -2048 to +2047. Without a prefix, a 4-bit field is zero-extended, and a missing field produces no operand.

For each accepted non-prefix instruction, the unit registers one result one cycle later. The result is a presence flag and a 16-bit operand value. A pipeline flush throws away both the held payload and any instruction offered in the same cycle.

Top module: `ixp_decoder`

## Requirements
- R1: While reset is asserted and until the first accepted instruction, `op_valid` and `op_present` are low and no payload is held.
- R2: A valid word whose bits [15:12] equal 4'hF is a prefix. Bits [11:0] of that word are held as the payload, and the word itself produces no `op_valid` pulse.
- R3: A load-immediate (bits [15:12] = 4'h1) with no prefix held yields `op_present`=1 and `op_value` = bits [3:0] zero-extended to 16 bits.
- R4: A load-immediate with a prefix held yields `op_value` = {payload, bits [3:0]} with `op_present`=1.
- R5: An indirect load (4'h2) or indirect store (4'h4) with a prefix held yields the payload sign-extended to 16 bits. Without a prefix, it yields `op_present`=0 and `op_value`=0.
- R6: A register-register add (4'h3) with a prefix held yields the payload sign-extended, covering -2048 to +2047. Without a prefix, it yields `op_present`=0 and `op_value`=0.
- R7: The held payload is used by exactly one instruction: the next valid non-prefix one. This holds even when that instruction's opcode (any other value) takes no immediate, which gives `op_present`=0 and `op_value`=0 and drops the payload.
- R8: When two prefixes arrive back to back, only the second payload is kept.
- R9: `flush` clears the held payload and discards any word offered in the same cycle; no `op_valid` pulse is produced for it.
- R10: Cycles with `instr_valid` low neither produce an output nor use up or alter the held payload.
- R11: The result of an accepted instruction appears on `op_valid`/`op_present`/`op_value` in the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr | input | 16 | Instruction word |
| instr_valid | input | 1 | `instr` carries a word this cycle |
| flush | input | 1 | Pipeline flush |
| op_valid | output | 1 | One-cycle strobe marking a decoded result |
| op_present | output | 1 | The instruction has an immediate operand |
| op_value | output | 16 | Final 16-bit operand, zero when absent |

## Verification
The bench goes after the ways a payload can leak into the wrong instruction:
- A payload followed by a non-immediate opcode, then a load-immediate. A decoder that failed to consume the payload would wrongly extend the later load.
- A payload left across idle cycles. A decoder that consumed it on invalid cycles would lose it.
- A flush between a payload and its user. Skipping the clear would leave a stale upper half in place.

It also covers the boundaries of the immediate ranges:
- Payload sign bits 0x800 and 0x7FF, which catch zero- versus sign-extension mistakes.
- Double prefixes, where keeping the first payload would corrupt the operand.
- Unprefixed zero-width forms, which must report no operand at all.

// File: rtl/ixp_pkg.sv
package ixp_pkg;

  typedef enum logic [1:0] {
    IMM_NONE  = 2'd0,
    IMM_SHORT = 2'd1,
    IMM_ZERO  = 2'd2
  } imm_class_e;

  localparam logic [3:0] OPC_PREFIX = 4'hF;
  localparam logic [3:0] OPC_LDI    = 4'h1;
  localparam logic [3:0] OPC_LDX    = 4'h2;
  localparam logic [3:0] OPC_ADDRR  = 4'h3;
  localparam logic [3:0] OPC_STX    = 4'h4;

  function automatic imm_class_e classify(input logic [3:0] opc);
    imm_class_e c;
    case (opc)
      OPC_LDI:                     c = IMM_SHORT;
      OPC_LDX, OPC_STX, OPC_ADDRR: c = IMM_ZERO;
      default:                     c = IMM_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ixp_rst_sync.sv
module ixp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ixp_prefix_hold.sv
module ixp_prefix_hold #(
  parameter int PAYLOAD_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_valid,
  input  logic                 word_is_prefix,
  input  logic                 flush,
  input  logic [PAYLOAD_W-1:0] payload_in,
  output logic                 held_valid,
  output logic [PAYLOAD_W-1:0] held_payload
);
  logic                 hv_d, hv_q;
  logic [PAYLOAD_W-1:0] hp_d, hp_q;
  logic                 hold_en;

  // A flush or any accepted word may change the held state.
  assign hold_en = flush | word_valid;

  always_comb begin
    hv_d = hv_q;
    hp_d = hp_q;
    if (flush) begin
      hv_d = 1'b0;
      hp_d = '0;
    end else if (word_valid && word_is_prefix) begin
      hv_d = 1'b1;
      hp_d = payload_in;
    end else if (word_valid) begin
      hv_d = 1'b0;
      hp_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
      hp_q <= '0;
    end else if (hold_en) begin
      hv_q <= hv_d;
      hp_q <= hp_d;
    end
  end

  assign held_valid   = hv_q;
  assign held_payload = hp_q;

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !held_valid);
  assert_single_use_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_is_prefix) |=> !held_valid);
  assert_last_prefix_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_is_prefix && !flush) |=> (held_valid && held_payload == $past(payload_in)));
  assert_idle_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && !flush) |=> ($stable(held_valid) && $stable(held_payload)));
endmodule

// File: rtl/ixp_operand_merge.sv
module ixp_operand_merge
  import ixp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int PAYLOAD_W = 12,
  parameter int SHORT_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  imm_class_e           cls,
  input  logic                 held_valid,
  input  logic [PAYLOAD_W-1:0] held_payload,
  input  logic [SHORT_W-1:0]   short_imm,
  output logic                 out_valid,
  output logic                 out_present,
  output logic [WORD_W-1:0]    out_value
);
  localparam int MERGE_W = PAYLOAD_W + SHORT_W;
  localparam int SEXT_W  = WORD_W - PAYLOAD_W;

  logic [MERGE_W-1:0] joined;
  logic [WORD_W-1:0]  joined_w, short_zext, payload_sext;

  assign joined       = {held_payload, short_imm};
  assign payload_sext = {{SEXT_W{held_payload[PAYLOAD_W-1]}}, held_payload};
  assign short_zext   = {{(WORD_W-SHORT_W){1'b0}}, short_imm};

  generate
    if (MERGE_W >= WORD_W) begin : g_trunc
      assign joined_w = joined[WORD_W-1:0];
    end else begin : g_pad
      assign joined_w = {{(WORD_W-MERGE_W){1'b0}}, joined};
    end
  endgenerate

  logic              pres_d, pres_q, val_d;
  logic [WORD_W-1:0] value_d, value_q;
  logic              val_q;

  always_comb begin
    pres_d  = 1'b0;
    value_d = '0;
    unique case (cls)
      IMM_SHORT: begin
        pres_d  = 1'b1;
        value_d = held_valid ? joined_w : short_zext;
      end
      IMM_ZERO: begin
        pres_d  = held_valid;
        value_d = held_valid ? payload_sext : '0;
      end
      default: begin
        pres_d  = 1'b0;
        value_d = '0;
      end
    endcase
    val_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= 1'b0;
    else        val_q <= val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q  <= 1'b0;
      value_q <= '0;
    end else if (fire) begin
      pres_q  <= pres_d;
      value_q <= value_d;
    end
  end

  assign out_valid   = val_q;
  assign out_present = pres_q;
  assign out_value   = value_q;

  assert_absent_is_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_present) |-> (out_value == '0));
  assert_short_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cls == IMM_SHORT) |=> (out_present && out_value[SHORT_W-1:0] == $past(short_imm)));
  assert_zero_needs_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cls == IMM_ZERO) |=> (out_present == $past(held_valid)));
endmodule

// File: rtl/ixp_decoder.sv
module ixp_decoder
  import ixp_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int OP_W    = 4,
  parameter int SHORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] instr,
  input  logic              instr_valid,
  input  logic              flush,
  output logic              op_valid,
  output logic              op_present,
  output logic [WORD_W-1:0] op_value
);
  localparam int PAYLOAD_W = WORD_W - OP_W;

  logic                 rst_i_n;
  logic [OP_W-1:0]      opc;
  logic                 is_prefix, accept, fire;
  imm_class_e           cls;
  logic                 held_valid;
  logic [PAYLOAD_W-1:0] held_payload;

  ixp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign opc       = instr[WORD_W-1 -: OP_W];
  assign is_prefix = (opc == OPC_PREFIX);
  assign cls       = classify(opc);
  assign accept    = instr_valid && !flush;
  assign fire      = accept && !is_prefix;

  ixp_prefix_hold #(.PAYLOAD_W(PAYLOAD_W)) u_hold (
    .clk            (clk),
    .rst_n          (rst_i_n),
    .word_valid     (accept),
    .word_is_prefix (is_prefix),
    .flush          (flush),
    .payload_in     (instr[PAYLOAD_W-1:0]),
    .held_valid     (held_valid),
    .held_payload   (held_payload)
  );

  ixp_operand_merge #(
    .WORD_W(WORD_W), .PAYLOAD_W(PAYLOAD_W), .SHORT_W(SHORT_W)
  ) u_merge (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .fire         (fire),
    .cls          (cls),
    .held_valid   (held_valid),
    .held_payload (held_payload),
    .short_imm    (instr[SHORT_W-1:0]),
    .out_valid    (op_valid),
    .out_present  (op_present),
    .out_value    (op_value)
  );

  assert_prefix_silent_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (instr_valid && is_prefix) |=> !op_valid);
  assert_flush_silent_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    flush |=> !op_valid);
  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !instr_valid |=> !op_valid);
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (instr_valid && !flush && !is_prefix) |=> op_valid);
endmodule

// File: tb/ixp_decoder_bench.sv
module ixp_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        instr_valid = 1'b0;
  logic        flush = 1'b0;
  logic        op_valid, op_present;
  logic [15:0] op_value;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic        m_held_v = 1'b0;
  logic [11:0] m_held   = '0;

  logic [15:0] q_val[$];
  logic        q_pres[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  ixp_decoder u_ixp_decoder (
    .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid),
    .flush(flush), .op_valid(op_valid), .op_present(op_present), .op_value(op_value)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: drives one cycle and pushes the expected result from the rules.
  task automatic drive(input logic [15:0] w, input logic v, input logic f, input string tag);
    logic [3:0]  opc;
    logic [15:0] ev;
    logic        ep;
    @(negedge clk); #1;
    instr = w; instr_valid = v; flush = f;
    opc = w[15:12];
    if (f) begin
      m_held_v = 1'b0; m_held = '0;
    end else if (v && opc == 4'hF) begin
      m_held_v = 1'b1; m_held = w[11:0];
    end else if (v) begin
      ev = '0; ep = 1'b0;
      if (opc == 4'h1) begin
        ep = 1'b1;
        ev = m_held_v ? {m_held, w[3:0]} : {12'h000, w[3:0]};
      end else if (opc == 4'h2 || opc == 4'h3 || opc == 4'h4) begin
        ep = m_held_v;
        ev = m_held_v ? {{4{m_held[11]}}, m_held} : 16'h0000;
      end
      q_val.push_back(ev); q_pres.push_back(ep); q_tag.push_back(tag);
      m_held_v = 1'b0; m_held = '0;
    end
  endtask

  // Monitor: compares each produced result with the oldest expected one.
  always @(negedge clk) begin
    if (rst_n && !done && op_valid) begin
      if (q_val.size() == 0) begin
        check("R2_R9_R10 unexpected op_valid", 16'd1, 16'd0);
      end else begin
        string t;
        logic [15:0] ev;
        logic ep;
        t = q_tag.pop_front(); ev = q_val.pop_front(); ep = q_pres.pop_front();
        check({t, " present"}, {15'd0, op_present}, {15'd0, ep});
        check({t, " value"}, op_value, ev);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1 op_valid in reset", {15'd0, op_valid}, 16'd0);
    check("R1 op_present in reset", {15'd0, op_present}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 op_valid after reset", {15'd0, op_valid}, 16'd0);

    drive(16'h1007, 1, 0, "R1_R3 ldi no prefix");
    drive(16'hFABC, 1, 0, "R2 prefix");
    drive(16'h1005, 1, 0, "R4_R11 ldi prefixed");
    drive(16'hF800, 1, 0, "R2 prefix");
    drive(16'h2120, 1, 0, "R5 ldx neg disp");
    drive(16'h2120, 1, 0, "R5 ldx no prefix");
    drive(16'hF7FF, 1, 0, "R2 prefix");
    drive(16'h4560, 1, 0, "R5 stx pos disp");
    drive(16'hF800, 1, 0, "R2 prefix");
    drive(16'h3120, 1, 0, "R6 add -2048");
    drive(16'hF7FF, 1, 0, "R2 prefix");
    drive(16'h3120, 1, 0, "R6 add +2047");
    drive(16'h3450, 1, 0, "R6 add no prefix");
    drive(16'hF123, 1, 0, "R2 prefix");
    drive(16'h0000, 1, 0, "R7 no-imm op consumes");
    drive(16'h100F, 1, 0, "R7 ldi after consume");
    drive(16'hF111, 1, 0, "R2 prefix");
    drive(16'hF222, 1, 0, "R8 second prefix");
    drive(16'h1003, 1, 0, "R8 ldi second wins");
    drive(16'hF999, 1, 0, "R2 prefix");
    drive(16'h1004, 1, 1, "R9 flushed word");
    drive(16'h1004, 1, 0, "R9 ldi after flush");
    drive(16'hF456, 1, 0, "R2 prefix");
    drive(16'h1111, 0, 0, "R10 idle");
    drive(16'h3333, 0, 0, "R10 idle");
    drive(16'h1009, 1, 0, "R10 ldi keeps prefix");
    drive(16'h0000, 0, 0, "idle");
    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 16'(q_val.size()), 16'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule